// File: doc/BRIEF.md
# Completion Reassembly Buffer with Per-Tag Tracking

This block sits on the receive side of a PCIe transaction-layer stream that is 256 bits wide. It takes in completion-with-data packets that answer read requests issued earlier by a DMA requester. The requester announces each read as it issues it, giving the tag and the requested length in dwords. The block gives every tag its own slot of 512 bytes, the largest read request size. A completion may answer only part of a request. Completions for different tags may arrive in any order, and a completion for another tag may arrive between two partial completions of one tag. Each payload beat is written into its tag's slot, at the offset given by the beats already received for that tag.

Data leaves on a valid/ready stream strictly in the order the requests were announced. A tag is retired once all of its beats have been sent, and it can then be announced again. On every accepted completion header, the block reports the completion's dword count back to the requester, which uses it to track reads in flight. A completion whose tag has no read outstanding is dropped and flagged.

Each packet starts with a header-only beat and its payload follows in full beats, eight dwords per beat. A beat never holds the end of one packet together with the start of the next. The input has no backpressure, because every outstanding tag already owns its slot.

Top module: `cplq_reassembler`

## Requirements
- R1: After reset, out_valid, retired_valid and drop_flag are all 0.
- R2: A beat with rx_valid=1 and rx_sop=1 is a header beat. Length in dwords is rx_data[9:0] and the tag is rx_data[76:72]. The payload beats follow it, with dword k of a beat at rx_data[32k+31:32k], and rx_eop marks the last payload beat.
- R3: One cycle after the header beat of a completion for an allocated tag is taken in, retired_valid is 1 for one cycle and retired_dw equals that header's Length.
- R4: A completion whose tag is not allocated is dropped. drop_flag pulses one cycle after its header beat, retired_valid stays 0 for it, and none of its payload appears on out_data.
- R5: A tag's payload beats are stored at the beat offset equal to the number of beats already received for that tag. A read split over several completions is therefore sent as the beats in the order they arrived.
- R6: Tags are emitted in the order their allocations were presented. out_valid stays 0 while the oldest outstanding tag has no unsent beat, even if later tags are complete.
- R7: A partial completion of one tag, then a completion of another tag, then the rest of the first tag, gives both tags' data intact and in allocation order.
- R8: When the oldest tag is waiting only for a payload beat, out_valid is 0 in the cycle that beat is presented and 1 in the cycle after it is taken in.
- R9: While out_valid=1 and out_ready=0, out_valid stays 1 and out_data and out_last stay unchanged in the next cycle.
- R10: out_last is 1 exactly on a tag's final beat, which is length/8 beats. After that beat the tag is freed and may be allocated again with new data.
- R11: An allocation (alloc_valid=1) names a tag that is not outstanding. Its length is a multiple of 8 dwords, from 8 to 128, and so is every completion Length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | The requester issues a read this cycle |
| alloc_tag | input | 5 | Tag of the issued read |
| alloc_len | input | 8 | Requested length in dwords |
| rx_valid | input | 1 | Receive beat valid |
| rx_sop | input | 1 | Header beat of a completion |
| rx_eop | input | 1 | Last payload beat of a completion |
| rx_data | input | 256 | Receive beat data |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream accepts the beat |
| out_data | output | 256 | Reassembled payload beat |
| out_last | output | 1 | Final beat of the current tag |
| retired_valid | output | 1 | A completion's dwords are reported |
| retired_dw | output | 10 | Dword count of that completion |
| drop_flag | output | 1 | A completion for an unallocated tag was dropped |

## Verification
The retired count and the drop flag are due one cycle after the rising edge that takes in the header beat. A payload beat can appear on the output in the cycle after the edge that writes it. Inputs change 1 ns after a rising edge, and every output is read at the following falling edge, so each reading falls in a well-defined cycle. A scoreboard queues the expected output beats in allocation order when each read is announced, and queues the expected retired counts when each header is driven. A monitor then compares every handshake and every retire pulse against those queues. It also checks that a stalled beat is held, and that out_valid stays low while the oldest tag is still waiting for data.

// File: rtl/cplq_pkg.sv
package cplq_pkg;
   // bit positions of the completion header fields that the receive side decodes
   localparam int HDR_LEN_LSB = 0;
   localparam int HDR_LEN_W   = 10;
   localparam int HDR_TAG_LSB = 72;
   localparam int DW_BITS     = 32;

   typedef enum logic [1:0] {
      PS_IDLE    = 2'd0,
      PS_PAYLOAD = 2'd1,
      PS_SKIP    = 2'd2
   } parse_st_e;
endpackage

// File: rtl/cplq_rx_parse.sv
module cplq_rx_parse
   import cplq_pkg::*;
#(
   parameter int DATA_W   = 256,
   parameter int NUM_TAGS = 32,
   parameter int TAG_W    = 5
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 rx_valid,
   input  logic                 rx_sop,
   input  logic                 rx_eop,
   input  logic [DATA_W-1:0]    rx_data,
   input  logic [NUM_TAGS-1:0]  tag_live,
   output logic                 hdr_ok,
   output logic                 hdr_drop,
   output logic [TAG_W-1:0]     hdr_tag,
   output logic [HDR_LEN_W-1:0] hdr_len,
   output logic                 pay_valid,
   output logic [TAG_W-1:0]     pay_tag,
   output logic [DATA_W-1:0]    pay_data
);
   parse_st_e        st_q;
   logic [TAG_W-1:0] cur_tag_q;
   logic             sop_seen;

   assign sop_seen  = rx_valid && rx_sop;
   assign hdr_tag   = rx_data[HDR_TAG_LSB +: TAG_W];
   assign hdr_len   = rx_data[HDR_LEN_LSB +: HDR_LEN_W];
   assign hdr_ok    = sop_seen && tag_live[hdr_tag];
   assign hdr_drop  = sop_seen && !tag_live[hdr_tag];
   assign pay_valid = rx_valid && !rx_sop && (st_q == PS_PAYLOAD);
   assign pay_tag   = cur_tag_q;
   assign pay_data  = rx_data;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q      <= PS_IDLE;
         cur_tag_q <= '0;
      end else if (rx_valid) begin
         if (rx_sop) begin
            st_q      <= tag_live[hdr_tag] ? PS_PAYLOAD : PS_SKIP;
            cur_tag_q <= hdr_tag;
         end else if (rx_eop) begin
            st_q <= PS_IDLE;
         end
      end
   end

   // R2: a header beat only arrives between packets
   a_r2_sop_between_packets: assert property (@(posedge clk) disable iff (!rst_n)
      sop_seen |-> st_q == PS_IDLE);
   // R2: payload beats only arrive inside a packet
   a_r2_payload_in_packet: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && !rx_sop) |-> st_q != PS_IDLE);
endmodule

// File: rtl/cplq_order_fifo.sv
module cplq_order_fifo #(
   parameter int DEPTH = 32,
   parameter int W     = 5
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] push_data,
   input  logic         pop,
   output logic [W-1:0] head,
   output logic         empty
);
   localparam int PTR_W = $clog2(DEPTH);
   localparam int CNT_W = PTR_W + 1;

   if (DEPTH != (1 << PTR_W)) begin : g_bad_depth
      $error("cplq_order_fifo: DEPTH must be a power of two");
   end

   logic [W-1:0]     store_q [DEPTH];
   logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
   logic [CNT_W-1:0] count_q;

   always_ff @(posedge clk) begin
      if (push) store_q[wr_ptr_q] <= push_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr_q <= '0;
         rd_ptr_q <= '0;
         count_q  <= '0;
      end else begin
         if (push) wr_ptr_q <= wr_ptr_q + 1'b1;
         if (pop)  rd_ptr_q <= rd_ptr_q + 1'b1;
         count_q <= count_q + CNT_W'(push) - CNT_W'(pop);
      end
   end

   assign head  = store_q[rd_ptr_q];
   assign empty = (count_q == '0);

   // R6: the allocation order queue never loses an entry
   a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> (count_q < CNT_W'(DEPTH)) || pop);
   a_r6_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !empty);
endmodule

// File: rtl/cplq_slot_mem.sv
module cplq_slot_mem #(
   parameter int DATA_W = 256,
   parameter int DEPTH  = 512,
   parameter int ADDR_W = 9
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] rdata
);
   if (DEPTH > (1 << ADDR_W)) begin : g_bad_addr
      $error("cplq_slot_mem: ADDR_W too small for DEPTH");
   end

   logic [DATA_W-1:0] mem_q [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem_q[waddr] <= wdata;
   end

   assign rdata = mem_q[raddr];
endmodule

// File: rtl/cplq_reassembler.sv
module cplq_reassembler
   import cplq_pkg::*;
#(
   parameter int DATA_W     = 256,
   parameter int NUM_TAGS   = 32,
   parameter int SLOT_BYTES = 512,
   localparam int TAG_W      = $clog2(NUM_TAGS),
   localparam int SLOT_DW    = SLOT_BYTES / 4,
   localparam int DWC_W      = $clog2(SLOT_DW) + 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 alloc_valid,
   input  logic [TAG_W-1:0]     alloc_tag,
   input  logic [DWC_W-1:0]     alloc_len,
   input  logic                 rx_valid,
   input  logic                 rx_sop,
   input  logic                 rx_eop,
   input  logic [DATA_W-1:0]    rx_data,
   output logic                 out_valid,
   input  logic                 out_ready,
   output logic [DATA_W-1:0]    out_data,
   output logic                 out_last,
   output logic                 retired_valid,
   output logic [HDR_LEN_W-1:0] retired_dw,
   output logic                 drop_flag
);
   localparam int DW_PER_BEAT = DATA_W / DW_BITS;
   localparam int BEAT_SHIFT  = $clog2(DW_PER_BEAT);
   localparam int SLOT_BEATS  = SLOT_DW / DW_PER_BEAT;
   localparam int BOFF_W      = $clog2(SLOT_BEATS);
   localparam int BEAT_W      = BOFF_W + 1;
   localparam int ADDR_W      = TAG_W + BOFF_W;
   localparam int MEM_DEPTH   = NUM_TAGS * SLOT_BEATS;

   // elaboration-time parameter checks
   if (DATA_W % DW_BITS != 0 || DW_PER_BEAT != (1 << BEAT_SHIFT)) begin : g_bad_width
      $error("cplq_reassembler: DATA_W must be a power-of-two count of dwords");
   end
   if (SLOT_BEATS != (1 << BOFF_W) || SLOT_DW % DW_PER_BEAT != 0) begin : g_bad_slot
      $error("cplq_reassembler: slot must hold a power-of-two count of beats");
   end
   if (NUM_TAGS != (1 << TAG_W)) begin : g_bad_tags
      $error("cplq_reassembler: NUM_TAGS must be a power of two");
   end
   if (HDR_TAG_LSB + TAG_W > DATA_W) begin : g_bad_hdr
      $error("cplq_reassembler: tag field lies outside the beat");
   end

   // parser outputs
   logic                 hdr_ok, hdr_drop, pay_valid;
   logic [TAG_W-1:0]     hdr_tag, pay_tag;
   logic [HDR_LEN_W-1:0] hdr_len;
   logic [DATA_W-1:0]    pay_data;

   // per-tag state views
   logic [NUM_TAGS-1:0]  live_v;
   logic [BEAT_W-1:0]    tot_a [NUM_TAGS];
   logic [BEAT_W-1:0]    wr_a  [NUM_TAGS];

   // release side
   logic [TAG_W-1:0]     head_tag;
   logic                 order_empty;
   logic [BEAT_W-1:0]    rd_beat_q;
   logic                 fire, free_now, head_live;
   logic [ADDR_W-1:0]    waddr, raddr;

   cplq_rx_parse #(.DATA_W(DATA_W), .NUM_TAGS(NUM_TAGS), .TAG_W(TAG_W)) u_parse (
      .clk      (clk),
      .rst_n    (rst_n),
      .rx_valid (rx_valid),
      .rx_sop   (rx_sop),
      .rx_eop   (rx_eop),
      .rx_data  (rx_data),
      .tag_live (live_v),
      .hdr_ok   (hdr_ok),
      .hdr_drop (hdr_drop),
      .hdr_tag  (hdr_tag),
      .hdr_len  (hdr_len),
      .pay_valid(pay_valid),
      .pay_tag  (pay_tag),
      .pay_data (pay_data)
   );

   // per-tag bookkeeping: one register set per tag
   for (genvar t = 0; t < NUM_TAGS; t++) begin : g_tag
      logic              live_q;
      logic [BEAT_W-1:0] tot_q, wr_q;
      logic [DWC_W-1:0]  rem_q;
      logic              alloc_hit, hdr_hit, pay_hit, free_hit;

      assign alloc_hit = alloc_valid && (alloc_tag == TAG_W'(t));
      assign hdr_hit   = hdr_ok && (hdr_tag == TAG_W'(t));
      assign pay_hit   = pay_valid && (pay_tag == TAG_W'(t));
      assign free_hit  = free_now && (head_tag == TAG_W'(t));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            live_q <= 1'b0;
            tot_q  <= '0;
            wr_q   <= '0;
            rem_q  <= '0;
         end else if (alloc_hit) begin
            live_q <= 1'b1;
            tot_q  <= BEAT_W'(alloc_len >> BEAT_SHIFT);
            wr_q   <= '0;
            rem_q  <= alloc_len;
         end else begin
            if (free_hit) live_q <= 1'b0;
            if (hdr_hit)  rem_q  <= rem_q - hdr_len[DWC_W-1:0];
            if (pay_hit)  wr_q   <= wr_q + 1'b1;
         end
      end

      assign live_v[t] = live_q;
      assign tot_a[t]  = tot_q;
      assign wr_a[t]   = wr_q;

      // R11: a completion never asks for more dwords than remain outstanding
      a_r11_len_fits: assert property (@(posedge clk) disable iff (!rst_n)
         hdr_hit |-> HDR_LEN_W'(rem_q) >= hdr_len);
      // R5: payload never runs past the end of the slot
      a_r5_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
         pay_hit |-> wr_q < tot_q);
      // R10: a freed tag is not outstanding afterwards
      a_r10_freed: assert property (@(posedge clk) disable iff (!rst_n)
         (free_hit && !alloc_hit) |=> !live_q);
   end

   cplq_order_fifo #(.DEPTH(NUM_TAGS), .W(TAG_W)) u_order (
      .clk      (clk),
      .rst_n    (rst_n),
      .push     (alloc_valid),
      .push_data(alloc_tag),
      .pop      (free_now),
      .head     (head_tag),
      .empty    (order_empty)
   );

   assign waddr = {pay_tag, wr_a[pay_tag][BOFF_W-1:0]};
   assign raddr = {head_tag, rd_beat_q[BOFF_W-1:0]};

   cplq_slot_mem #(.DATA_W(DATA_W), .DEPTH(MEM_DEPTH), .ADDR_W(ADDR_W)) u_mem (
      .clk  (clk),
      .we   (pay_valid),
      .waddr(waddr),
      .wdata(pay_data),
      .raddr(raddr),
      .rdata(out_data)
   );

   assign head_live = !order_empty && live_v[head_tag];
   assign out_valid = head_live && (rd_beat_q < wr_a[head_tag]);
   assign out_last  = (rd_beat_q == tot_a[head_tag] - BEAT_W'(1));
   assign fire      = out_valid && out_ready;
   assign free_now  = fire && out_last;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_beat_q <= '0;
      end else if (free_now) begin
         rd_beat_q <= '0;
      end else if (fire) begin
         rd_beat_q <= rd_beat_q + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         retired_valid <= 1'b0;
         retired_dw    <= '0;
         drop_flag     <= 1'b0;
      end else begin
         retired_valid <= hdr_ok;
         retired_dw    <= hdr_ok ? hdr_len : '0;
         drop_flag     <= hdr_drop;
      end
   end

   // R9: a stalled beat is held
   a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> out_valid && $stable(out_data) && $stable(out_last));
   // R4: a dropped completion is never reported as retired
   a_r4_drop_excl: assert property (@(posedge clk) disable iff (!rst_n)
      drop_flag |-> !retired_valid);
   // R11: allocations name a free tag and a legal whole-beat length
   a_r11_alloc_legal: assert property (@(posedge clk) disable iff (!rst_n)
      alloc_valid |-> !live_v[alloc_tag] && (alloc_len != '0)
                      && (alloc_len[BEAT_SHIFT-1:0] == '0)
                      && (alloc_len <= DWC_W'(SLOT_DW)));
   // R6: the release side only moves on the tag at the head of the order
   a_r6_head_moves: assert property (@(posedge clk) disable iff (!rst_n)
      free_now |=> !live_v[$past(head_tag)]);
endmodule

// File: tb/sim_cplq_reassembler.sv
module sim_cplq_reassembler;
   localparam int DATA_W   = 256;
   localparam int NUM_TAGS = 32;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic               rst_n = 1'b0;
   logic               alloc_valid = 1'b0;
   logic [4:0]         alloc_tag = '0;
   logic [7:0]         alloc_len = '0;
   logic               rx_valid = 1'b0, rx_sop = 1'b0, rx_eop = 1'b0;
   logic [DATA_W-1:0]  rx_data = '0;
   logic               out_valid, out_last, out_ready = 1'b0;
   logic [DATA_W-1:0]  out_data;
   logic               retired_valid, drop_flag;
   logic [9:0]         retired_dw;

   cplq_reassembler u0 (
      .clk(clk), .rst_n(rst_n),
      .alloc_valid(alloc_valid), .alloc_tag(alloc_tag), .alloc_len(alloc_len),
      .rx_valid(rx_valid), .rx_sop(rx_sop), .rx_eop(rx_eop), .rx_data(rx_data),
      .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
      .out_last(out_last), .retired_valid(retired_valid), .retired_dw(retired_dw),
      .drop_flag(drop_flag)
   );

   int checks = 0, fails = 0, cycles = 0;
   logic [DATA_W:0] exp_q[$];
   int tag_q[$];
   int exp_ret_q[$];
   int exp_drops = 0, seen_drops = 0;
   int seq_of[NUM_TAGS];
   bit live_tb[NUM_TAGS];
   int next_seq = 1;
   int ready_mode = 0;
   logic [15:0] lfsr = 16'hACE1;

   function automatic logic [DATA_W-1:0] pat(int seq, int beat);
      logic [DATA_W-1:0] r;
      for (int i = 0; i < DATA_W / 32; i++)
         r[i*32 +: 32] = {seq[11:0], beat[7:0], 4'(i), 8'hA5};
      return r;
   endfunction

   task automatic check(bit ok, string req, string what,
                        logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic finish_up();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   endtask

   // driver tasks: inputs change 1 ns after the rising edge
   task automatic alloc(int tag, int len);
      @(posedge clk); #1;
      alloc_valid = 1'b1; alloc_tag = 5'(tag); alloc_len = 8'(len);
      seq_of[tag] = next_seq++;
      live_tb[tag] = 1'b1;
      for (int b = 0; b < len / 8; b++) begin
         exp_q.push_back({(b == len / 8 - 1), pat(seq_of[tag], b)});
         tag_q.push_back(tag);
      end
      @(posedge clk); #1;
      alloc_valid = 1'b0;
   endtask

   task automatic drive_hdr(int tag, int ndw);
      @(posedge clk); #1;
      rx_valid = 1'b1; rx_sop = 1'b1; rx_eop = 1'b0; rx_data = '0;
      rx_data[9:0] = 10'(ndw);
      rx_data[76:72] = 5'(tag);
      if (live_tb[tag]) exp_ret_q.push_back(ndw);
      else exp_drops++;
   endtask

   task automatic drive_pay(int tag, int beat, bit last);
      @(posedge clk); #1;
      rx_valid = 1'b1; rx_sop = 1'b0; rx_eop = last;
      rx_data = pat(live_tb[tag] ? seq_of[tag] : 0, beat);
   endtask

   task automatic idle();
      @(posedge clk); #1;
      rx_valid = 1'b0; rx_sop = 1'b0; rx_eop = 1'b0;
   endtask

   task automatic send(int tag, int ndw, int first);
      drive_hdr(tag, ndw);
      for (int i = 0; i < ndw / 8; i++) drive_pay(tag, first + i, i == ndw / 8 - 1);
      idle();
   endtask

   task automatic drain();
      while (exp_q.size() != 0) @(negedge clk);
      @(negedge clk);
   endtask

   // ready pattern generator
   initial begin
      forever begin
         @(posedge clk); #1;
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         case (ready_mode)
            0: out_ready = 1'b1;
            1: out_ready = lfsr[0] | lfsr[3];
            default: out_ready = 1'b0;
         endcase
      end
   end

   // monitor / scoreboard, sampling on the falling edge
   initial begin
      logic pv, pr;
      logic [DATA_W-1:0] pd;
      logic [DATA_W:0] e;
      int t, r;
      pv = 1'b0; pr = 1'b0; pd = '0;
      forever begin
         @(negedge clk);
         if (rst_n) begin
            if (pv && !pr) begin
               check(out_valid == 1'b1, "R9", "valid held under stall", DATA_W'(out_valid), 1);
               check(out_data == pd, "R9", "data held under stall", out_data, pd);
            end
            if (out_valid && out_ready) begin
               if (exp_q.size() == 0) begin
                  check(1'b0, "R6", "unexpected output beat", out_data, '0);
               end else begin
                  e = exp_q.pop_front();
                  t = tag_q.pop_front();
                  check(out_data == e[DATA_W-1:0], "R5 R6", "output beat", out_data, e[DATA_W-1:0]);
                  check(out_last == e[DATA_W], "R10", "last marker", DATA_W'(out_last), DATA_W'(e[DATA_W]));
                  if (e[DATA_W]) live_tb[t] = 1'b0;
               end
            end
            if (retired_valid) begin
               if (exp_ret_q.size() == 0) begin
                  check(1'b0, "R3", "unexpected retire", DATA_W'(retired_dw), '0);
               end else begin
                  r = exp_ret_q.pop_front();
                  check(retired_dw == 10'(r), "R3", "retired dword count", DATA_W'(retired_dw), DATA_W'(r));
               end
            end
            if (drop_flag) seen_drops++;
            pv = out_valid; pr = out_ready; pd = out_data;
         end
      end
   end

   // watchdog
   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 100000) begin
            check(1'b0, "R6", "watchdog expired", DATA_W'(cycles), 100000);
            finish_up();
         end
      end
   end

   initial begin
      repeat (4) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      check(out_valid == 1'b0, "R1", "out_valid after reset", DATA_W'(out_valid), 0);
      check(retired_valid == 1'b0, "R1", "retired_valid after reset", DATA_W'(retired_valid), 0);
      check(drop_flag == 1'b0, "R1", "drop_flag after reset", DATA_W'(drop_flag), 0);

      // R2 R3: one whole completion
      alloc(0, 16);
      send(0, 16, 0);
      drain();

      // R7: partial, other tag, remainder
      alloc(11, 64);
      alloc(12, 64);
      send(11, 48, 0);
      send(12, 64, 0);
      send(11, 16, 6);
      drain();

      // R6: completions in reverse order under random ready
      ready_mode = 1;
      alloc(1, 8);
      alloc(2, 16);
      alloc(3, 32);
      send(3, 32, 0);
      send(2, 16, 0);
      @(negedge clk);
      check(out_valid == 1'b0, "R6", "no release before oldest tag", DATA_W'(out_valid), 0);
      send(1, 8, 0);
      drain();

      // R4: completion for an unallocated tag
      ready_mode = 0;
      send(20, 8, 0);
      repeat (2) @(negedge clk);
      check(out_valid == 1'b0, "R4", "dropped payload not released", DATA_W'(out_valid), 0);
      check(seen_drops == exp_drops, "R4", "drop pulses", DATA_W'(seen_drops), DATA_W'(exp_drops));

      // R8: cycle of first availability, R9 stall
      ready_mode = 2;
      alloc(5, 8);
      drive_hdr(5, 8);
      drive_pay(5, 0, 1'b1);
      @(negedge clk);
      check(out_valid == 1'b0, "R8", "valid while beat presented", DATA_W'(out_valid), 0);
      idle();
      @(negedge clk);
      check(out_valid == 1'b1, "R8", "valid after beat taken", DATA_W'(out_valid), 1);
      check(out_data == pat(seq_of[5], 0), "R8", "data after beat taken", out_data, pat(seq_of[5], 0));
      repeat (3) @(posedge clk);
      ready_mode = 0;
      drain();

      // R5 R11: largest read split into four completions
      ready_mode = 1;
      alloc(7, 128);
      alloc(8, 8);
      send(8, 8, 0);
      send(7, 32, 0);
      send(7, 32, 4);
      send(7, 32, 8);
      send(7, 32, 12);
      drain();

      // R10: reuse of a freed tag carries new data
      alloc(0, 8);
      send(0, 8, 0);
      drain();

      check(exp_ret_q.size() == 0, "R3", "retire reports outstanding", DATA_W'(exp_ret_q.size()), 0);
      check(seen_drops == exp_drops, "R4", "final drop pulses", DATA_W'(seen_drops), DATA_W'(exp_drops));
      check(exp_q.size() == 0, "R6", "beats outstanding", DATA_W'(exp_q.size()), 0);
      finish_up();
   end
endmodule